// File: doc/BRIEF.md
# DRAM Controller Operating State Sequencer

This block holds the top-level operating mode of a DRAM controller. Software issues a mode command (a 3-bit code qualified by a valid bit), and the block moves between its settled modes. These are memory initialisation, configuration, host access and low power.

Every accepted move passes through a transient request state. The block stays in that state until the matching handshake input arrives from the controller, PHY or DRAM side. The current mode is reported on a 3-bit status output, which software polls until the state settles.

Host traffic is allowed only while the block is in the access state. While a low-power entry or exit is pending, the block raises a request level toward the PHY and DRAM side and holds it until that side acknowledges. A command that is not legal from the current state changes nothing.

Top module: `opstate_ctrl`

## Requirements
- R1: While rst_ni is low, and on the first edge after its release with no command, state_o is 0 and host_en_o, lp_enter_req_o and lp_exit_req_o are all 0. Reset is asynchronous.
- R2: state_o encodes 0 init-memory, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request and 7 low-power-exit-request.
- R3: A command is taken from cmd_i on a rising edge where cmd_valid_i is 1. The codes are 1 config, 2 go, 3 sleep and 4 wakeup. Code 0 (init) and codes 5 to 7 are ignored in every state.
- R4: A config command in state 0 or 3 moves the state to 2 on that edge. The state stays 2 until an edge sees drain_done_i high, and then becomes 1.
- R5: A go command in state 1 moves the state to 4. The state stays 4 until an edge sees phy_ready_i high, and then becomes 3.
- R6: A sleep command in state 3 moves the state to 6, with lp_enter_req_o high for as long as the state is 6. When an edge sees lp_enter_ack_i high, the state becomes 5.
- R7: A wakeup command in state 5 moves the state to 7, with lp_exit_req_o high for as long as the state is 7. When an edge sees lp_exit_ack_i high, the state becomes 3.
- R8: An illegal command leaves the state unchanged. Illegal commands are go outside state 1, sleep outside state 3, wakeup outside state 5, config outside states 0 and 3, and any command in a request state (2, 4, 6, 7). In particular, config in state 5 is refused, so software must wake the block first.
- R9: host_en_o is 1 exactly when state_o is 3. At most one of host_en_o, lp_enter_req_o and lp_exit_req_o is high at a time.
- R10: A handshake input (drain_done_i, phy_ready_i, lp_enter_ack_i or lp_exit_ack_i) has no effect outside its own request state.
- R11: A request state lasts at least one cycle, even when its handshake input is already high on the edge that enters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Mode command code |
| drain_done_i | input | 1 | Host traffic drained; completes config request |
| phy_ready_i | input | 1 | Datapath ready; completes access request |
| lp_enter_ack_i | input | 1 | Low-power entry acknowledge |
| lp_exit_ack_i | input | 1 | Low-power exit acknowledge |
| state_o | output | 3 | Current operating state |
| host_en_o | output | 1 | Host access enable |
| lp_enter_req_o | output | 1 | Low-power entry request level |
| lp_exit_req_o | output | 1 | Low-power exit request level |

## Verification
The properties place no limits on the handshake inputs: they may rise in any state, at any time. The properties do take for granted that cmd_i carries a defined code whenever cmd_valid_i is high, and that all inputs settle before each rising edge. The stimulus drives every input on the falling edge and holds it for exactly one rising edge, then returns it to zero. Stray acknowledges and illegal codes are injected only as whole-cycle pulses, so each one is seen by exactly one edge.

// File: rtl/opstate_pkg.sv
package opstate_pkg;
  localparam int unsigned StW  = 3;
  localparam int unsigned CmdW = 3;

  typedef enum logic [StW-1:0] {
    ST_INIT_MEM = 3'd0,
    ST_CONFIG   = 3'd1,
    ST_CFG_REQ  = 3'd2,
    ST_ACCESS   = 3'd3,
    ST_ACC_REQ  = 3'd4,
    ST_LOW_PWR  = 3'd5,
    ST_LP_ENTER = 3'd6,
    ST_LP_EXIT  = 3'd7
  } op_state_e;

  localparam logic [CmdW-1:0] CMD_INIT   = 3'd0;
  localparam logic [CmdW-1:0] CMD_CONFIG = 3'd1;
  localparam logic [CmdW-1:0] CMD_GO     = 3'd2;
  localparam logic [CmdW-1:0] CMD_SLEEP  = 3'd3;
  localparam logic [CmdW-1:0] CMD_WAKEUP = 3'd4;

  function automatic logic is_request(op_state_e s);
    return (s == ST_CFG_REQ) || (s == ST_ACC_REQ) ||
           (s == ST_LP_ENTER) || (s == ST_LP_EXIT);
  endfunction
endpackage

// File: rtl/opstate_cmd_filter.sv
module opstate_cmd_filter
  import opstate_pkg::*;
(
  input  op_state_e       state_i,
  input  logic            cmd_valid_i,
  input  logic [CmdW-1:0] cmd_i,
  output logic            accept_o,
  output op_state_e       target_o
);
  // only settled states take commands; init and spare codes never match
  always_comb begin
    accept_o = 1'b0;
    target_o = state_i;
    if (cmd_valid_i) begin
      case (state_i)
        ST_INIT_MEM: begin
          if (cmd_i == CMD_CONFIG) begin
            accept_o = 1'b1;
            target_o = ST_CFG_REQ;
          end
        end
        ST_CONFIG: begin
          if (cmd_i == CMD_GO) begin
            accept_o = 1'b1;
            target_o = ST_ACC_REQ;
          end
        end
        ST_ACCESS: begin
          if (cmd_i == CMD_CONFIG) begin
            accept_o = 1'b1;
            target_o = ST_CFG_REQ;
          end else if (cmd_i == CMD_SLEEP) begin
            accept_o = 1'b1;
            target_o = ST_LP_ENTER;
          end
        end
        ST_LOW_PWR: begin
          if (cmd_i == CMD_WAKEUP) begin
            accept_o = 1'b1;
            target_o = ST_LP_EXIT;
          end
        end
        default: begin
          accept_o = 1'b0;
          target_o = state_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/opstate_core.sv
module opstate_core
  import opstate_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      accept_i,
  input  op_state_e target_i,
  input  logic      drain_done_i,
  input  logic      phy_ready_i,
  input  logic      lp_enter_ack_i,
  input  logic      lp_exit_ack_i,
  output op_state_e state_o
);
  op_state_e state_q, state_d;

  // handshakes are only looked at from the matching request state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_CFG_REQ:  if (drain_done_i)   state_d = ST_CONFIG;
      ST_ACC_REQ:  if (phy_ready_i)    state_d = ST_ACCESS;
      ST_LP_ENTER: if (lp_enter_ack_i) state_d = ST_LOW_PWR;
      ST_LP_EXIT:  if (lp_exit_ack_i)  state_d = ST_ACCESS;
      default:     if (accept_i)       state_d = target_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_INIT_MEM;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/opstate_out.sv
module opstate_out
  import opstate_pkg::*;
(
  input  op_state_e state_i,
  output logic      host_en_o,
  output logic      lp_enter_req_o,
  output logic      lp_exit_req_o
);
  assign host_en_o      = (state_i == ST_ACCESS);
  assign lp_enter_req_o = (state_i == ST_LP_ENTER);
  assign lp_exit_req_o  = (state_i == ST_LP_EXIT);
endmodule

// File: rtl/opstate_ctrl.sv
module opstate_ctrl
  import opstate_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [CmdW-1:0] cmd_i,
  input  logic            drain_done_i,
  input  logic            phy_ready_i,
  input  logic            lp_enter_ack_i,
  input  logic            lp_exit_ack_i,
  output logic [StW-1:0]  state_o,
  output logic            host_en_o,
  output logic            lp_enter_req_o,
  output logic            lp_exit_req_o
);
  op_state_e cur_state;
  op_state_e cmd_target;
  logic      cmd_accept;

  opstate_cmd_filter u_filter (
    .state_i     (cur_state),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .accept_o    (cmd_accept),
    .target_o    (cmd_target)
  );

  opstate_core u_core (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .accept_i       (cmd_accept),
    .target_i       (cmd_target),
    .drain_done_i   (drain_done_i),
    .phy_ready_i    (phy_ready_i),
    .lp_enter_ack_i (lp_enter_ack_i),
    .lp_exit_ack_i  (lp_exit_ack_i),
    .state_o        (cur_state)
  );

  opstate_out u_out (
    .state_i        (cur_state),
    .host_en_o      (host_en_o),
    .lp_enter_req_o (lp_enter_req_o),
    .lp_exit_req_o  (lp_exit_req_o)
  );

  assign state_o = cur_state;
endmodule

// File: rtl/opstate_ctrl_chk.sv
module opstate_ctrl_chk
  import opstate_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_valid_i,
  input logic [CmdW-1:0] cmd_i,
  input logic            drain_done_i,
  input logic            phy_ready_i,
  input logic            lp_enter_ack_i,
  input logic            lp_exit_ack_i,
  input logic [StW-1:0]  state_o,
  input logic            host_en_o,
  input logic            lp_enter_req_o,
  input logic            lp_exit_req_o
);
  a_r4_cfg_req_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_CFG_REQ && drain_done_i) |=> state_o == ST_CONFIG);

  a_r4_cfg_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_CFG_REQ && !drain_done_i) |=> state_o == ST_CFG_REQ);

  a_r5_config_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_CONFIG |=> (state_o == ST_CONFIG || state_o == ST_ACC_REQ));

  a_r6_enter_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_LP_ENTER && !lp_enter_ack_i) |=> (state_o == ST_LP_ENTER && lp_enter_req_o));

  a_r11_sleep_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ACCESS && cmd_valid_i && cmd_i == CMD_SLEEP) |=> state_o == ST_LP_ENTER);

  a_r7_exit_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_LP_EXIT && lp_exit_ack_i) |=> (state_o == ST_ACCESS && host_en_o));

  a_r8_lp_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_LOW_PWR && !(cmd_valid_i && cmd_i == CMD_WAKEUP)) |=> state_o == ST_LOW_PWR);

  a_r9_host_en_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(host_en_o) |-> ($past(state_o) == ST_ACC_REQ || $past(state_o) == ST_LP_EXIT));

  a_r9_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({host_en_o, lp_enter_req_o, lp_exit_req_o}));
endmodule

bind opstate_ctrl opstate_ctrl_chk u_chk (.*);

// File: tb/sim_opstate_ctrl.sv
module sim_opstate_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_i = 3'd0;
  logic       drain_done_i = 1'b0;
  logic       phy_ready_i = 1'b0;
  logic       lp_enter_ack_i = 1'b0;
  logic       lp_exit_ack_i = 1'b0;
  logic [2:0] state_o;
  logic       host_en_o, lp_enter_req_o, lp_exit_req_o;

  typedef struct {
    logic [2:0] st;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;

  always #5 clk_i = ~clk_i;

  opstate_ctrl u0 (.*);

  task automatic check_out(input logic [2:0] st, input string tag);
    logic [5:0] act, exp;
    act = {state_o, host_en_o, lp_enter_req_o, lp_exit_req_o};
    exp = {st, st == 3'd3, st == 3'd6, st == 3'd7};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s state/host/enter/exit actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: one edge of stimulus, expected state pushed for the monitor
  task automatic step(input logic v, input logic [2:0] c, input logic dd, input logic pr,
                      input logic ea, input logic xa, input logic [2:0] st, input string tag);
    @(negedge clk_i);
    cmd_valid_i    = v;
    cmd_i          = c;
    drain_done_i   = dd;
    phy_ready_i    = pr;
    lp_enter_ack_i = ea;
    lp_exit_ack_i  = xa;
    exp_q.push_back('{st: st, tag: tag});
  endtask

  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check_out(e.st, e.tag);
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    check_out(3'd0, "R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 3'd0, 0, 0, 0, 0, 3'd0, "R1 idle after reset");
    // illegal and spare codes in init-memory
    step(1, 3'd2, 0, 0, 0, 0, 3'd0, "R8 go from init");
    step(1, 3'd3, 0, 0, 0, 0, 3'd0, "R8 sleep from init");
    step(1, 3'd4, 0, 0, 0, 0, 3'd0, "R8 wakeup from init");
    step(1, 3'd0, 0, 0, 0, 0, 3'd0, "R3 init code ignored");
    step(1, 3'd5, 0, 0, 0, 0, 3'd0, "R3 code5 ignored");
    step(1, 3'd7, 0, 0, 0, 0, 3'd0, "R3 code7 ignored");
    step(0, 3'd0, 1, 1, 1, 1, 3'd0, "R10 stray handshakes in init");
    step(1, 3'd1, 1, 0, 0, 0, 3'd2, "R11 cfg request held one cycle");
    step(0, 3'd0, 1, 0, 0, 0, 3'd1, "R4 drain completes config");
    // config state
    step(1, 3'd3, 0, 0, 0, 0, 3'd1, "R8 sleep from config");
    step(1, 3'd1, 0, 0, 0, 0, 3'd1, "R8 config from config");
    step(0, 3'd0, 0, 1, 0, 0, 3'd1, "R10 phy_ready in config");
    step(1, 3'd2, 0, 0, 0, 0, 3'd4, "R5 go enters access request");
    step(0, 3'd0, 0, 0, 0, 0, 3'd4, "R5 access request waits");
    step(1, 3'd1, 1, 0, 0, 0, 3'd4, "R8 command during request");
    step(0, 3'd0, 0, 1, 0, 0, 3'd3, "R5 R9 ready reaches access");
    // access state
    step(1, 3'd4, 0, 0, 0, 0, 3'd3, "R8 wakeup from access");
    step(1, 3'd2, 0, 0, 0, 0, 3'd3, "R8 go from access");
    step(1, 3'd6, 0, 0, 0, 0, 3'd3, "R3 code6 in access");
    step(0, 3'd0, 0, 0, 1, 1, 3'd3, "R10 stray lp acks in access");
    step(1, 3'd3, 0, 0, 1, 0, 3'd6, "R6 R11 sleep enters entry request");
    step(0, 3'd0, 0, 0, 0, 1, 3'd6, "R6 entry waits for its ack");
    step(0, 3'd0, 0, 0, 1, 0, 3'd5, "R6 ack reaches low power");
    // low power
    step(1, 3'd1, 0, 0, 0, 0, 3'd5, "R8 config from low power");
    step(1, 3'd2, 0, 0, 0, 0, 3'd5, "R8 go from low power");
    step(0, 3'd0, 1, 1, 0, 1, 3'd5, "R10 stray acks in low power");
    step(1, 3'd4, 0, 0, 0, 0, 3'd7, "R7 wakeup enters exit request");
    step(0, 3'd0, 0, 0, 1, 0, 3'd7, "R7 exit waits for its ack");
    step(0, 3'd0, 0, 0, 0, 1, 3'd3, "R7 R9 ack returns to access");
    // config from access, then go with ready already high
    step(1, 3'd1, 0, 0, 0, 0, 3'd2, "R4 config from access");
    step(0, 3'd0, 0, 0, 0, 0, 3'd2, "R4 config request waits");
    step(0, 3'd0, 1, 0, 0, 0, 3'd1, "R4 drain completes config");
    step(1, 3'd2, 0, 1, 0, 0, 3'd4, "R11 access request held one cycle");
    step(0, 3'd0, 0, 1, 0, 0, 3'd3, "R5 ready reaches access");
    step(0, 3'd0, 0, 0, 0, 0, 3'd3, "R2 access stays");
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    while (exp_q.size() > 0) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check_out(3'd0, "R1 asynchronous reset");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule